// File: doc/BRIEF.md
# Interrupt Command Destination Decoder

This block takes one interprocessor interrupt command per cycle and turns it into a delivery mask with one bit per local interrupt unit. A command names its targets in one of two ways. It can use a shorthand: the sender alone, every unit, or every unit except the sender. Otherwise it gives an 8-bit destination. The block reads that destination either as a physical unit ID or as a logical address. A logical address is compared against each unit's logical ID, using the flat or cluster format that the unit has configured. A destination of all ones reaches every unit in both addressing schemes.

The block also screens out combinations of delivery mode, trigger mode and level bit that are not allowed. For these it raises an error flag and delivers to no unit. It recognises the INIT level-deassert message and reports it on a flag of its own. Commands are accepted on a valid/ready handshake with ready always high. The result appears one cycle after acceptance. A two-state machine (EMPTY, LOADED) drives the result-valid flag:
- ACCEPT takes EMPTY to LOADED when a command arrives.
- STREAM keeps LOADED on back-to-back commands.
- DRAIN takes LOADED back to EMPTY on an idle cycle.

Top module: `ipi_dest_decoder`

## Requirements
- R1: `cmd_ready` is always 1. A command with `cmd_valid` high produces `res_valid` high on the next cycle, together with its mask and flags. A cycle without a command produces `res_valid` low on the next cycle, with the mask and flags at zero.
- R2: With shorthand 00 (none) and `cmd_dest_logical`=0, a destination of 00h–FEh sets only the bits of units whose `unit_id` equals it. A destination of FFh sets every bit.
- R3: With shorthand 00 and `cmd_dest_logical`=1, a unit with `unit_flat`=1 (flat format) matches when its logical ID ANDed with the destination is nonzero.
- R4: With shorthand 00 and `cmd_dest_logical`=1, a unit with `unit_flat`=0 (cluster format) matches only when two conditions hold: the upper nibbles of its logical ID and the destination are equal, and the lower nibbles share at least one set bit.
- R5: A logical destination of FFh matches every unit, whatever its format.
- R6: Shorthand 01 sets only bit `cmd_sender`. Shorthand 10 sets every bit. Shorthand 11 sets every bit except bit `cmd_sender`. For all three, the destination field and the destination mode have no effect.
- R7: With shorthand 10, any delivery mode other than fixed (000) is an error. Fixed is legal there with both edge (`cmd_trig_level`=0) and level (`cmd_trig_level`=1) trigger.
- R8: Delivery modes are encoded as follows: fixed 000, lowest-priority 001, SMI 010, NMI 100, INIT 101, Start-Up 110. A level-triggered SMI or Start-Up is an error under shorthands 00, 01 and 11. Level-triggered fixed, lowest-priority, NMI and INIT with level bit 1 are legal under shorthand 11.
- R9: A level-triggered INIT with `cmd_level`=0 is legal unless the shorthand is 10. It sets `res_deassert` and uses the normal destination mask. Any other command with `cmd_level`=0 is an error.
- R10: Delivery codes 011 and 111 are reserved and always an error. Whenever `res_error` is 1, `res_mask` is all zero and `res_deassert` is 0.
- R11: While reset is held, and on the first cycle after it, `res_valid`, `res_mask`, `res_error` and `res_deassert` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1: a command can be taken every cycle |
| cmd_shorthand | input | 2 | 00 none, 01 self, 10 all including self, 11 all excluding self |
| cmd_dest_logical | input | 1 | 0 physical destination, 1 logical destination |
| cmd_dest | input | ID_W | Destination ID or logical address |
| cmd_dlv | input | 3 | Delivery mode code |
| cmd_trig_level | input | 1 | 0 edge, 1 level trigger |
| cmd_level | input | 1 | Level bit |
| cmd_sender | input | SND_W | Index of the sending unit |
| unit_id | input | NUM_UNITS*ID_W | Physical ID of each unit, unit i at bits [i*ID_W +: ID_W] |
| unit_ldr | input | NUM_UNITS*ID_W | Logical ID of each unit, same packing |
| unit_flat | input | NUM_UNITS | Per unit: 1 flat format, 0 cluster format |
| res_valid | output | 1 | Result present |
| res_mask | output | NUM_UNITS | Delivery mask |
| res_error | output | 1 | Command combination not allowed |
| res_deassert | output | 1 | Command is an INIT level-deassert |

## Verification
The bench builds the decoder with NUM_UNITS=8, so the sender index has 3 bits. Every index, including the top one, can then be the sender and be excluded within a short run. Four of the eight units use flat format and four use cluster format, split over two clusters. A single logical address can therefore hit flat units and cluster units together, which checks that each unit follows its own format. Directed commands cover each shorthand, each legality row and the deassert case. A seeded pseudo-random stream follows them, mixing back-to-back and gapped commands.

// File: rtl/ipi_dec_pkg.sv
package ipi_dec_pkg;

    typedef enum logic [1:0] {
        SH_NONE     = 2'b00,
        SH_SELF     = 2'b01,
        SH_ALL_INCL = 2'b10,
        SH_ALL_EXCL = 2'b11
    } shorthand_e;

    typedef enum logic [2:0] {
        DM_FIXED   = 3'b000,
        DM_LOWEST  = 3'b001,
        DM_SMI     = 3'b010,
        DM_RSVD3   = 3'b011,
        DM_NMI     = 3'b100,
        DM_INIT    = 3'b101,
        DM_STARTUP = 3'b110,
        DM_RSVD7   = 3'b111
    } dlv_mode_e;

    typedef enum logic [0:0] {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } dec_state_e;

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] dest,
    input  logic            logical_mode,
    input  logic [ID_W-1:0] phys_id,
    input  logic [ID_W-1:0] log_id,
    input  logic            flat_fmt,
    output logic            hit
);
    localparam int NIB = ID_W / 2;

    logic bcast;
    logic phys_hit;
    logic flat_hit;
    logic clus_hit;

    always_comb begin
        bcast    = &dest;
        phys_hit = (dest == phys_id);
        flat_hit = |(dest & log_id);
        clus_hit = (dest[ID_W-1:NIB] == log_id[ID_W-1:NIB]) &&
                   (|(dest[NIB-1:0] & log_id[NIB-1:0]));
        if (bcast)
            hit = 1'b1;
        else if (!logical_mode)
            hit = phys_hit;
        else if (flat_fmt)
            hit = flat_hit;
        else
            hit = clus_hit;
    end
endmodule

// File: rtl/ipi_cmd_legality.sv
module ipi_cmd_legality
    import ipi_dec_pkg::*;
(
    input  logic [1:0] shorthand,
    input  logic [2:0] dlv,
    input  logic       trig_level,
    input  logic       level_bit,
    output logic       illegal,
    output logic       deassert
);
    shorthand_e sh;
    dlv_mode_e  dm;
    logic       reserved_code;
    logic       bad_level0;
    logic       bad_broadcast;
    logic       bad_level_trig;

    always_comb begin
        sh = shorthand_e'(shorthand);
        dm = dlv_mode_e'(dlv);
        reserved_code  = (dm == DM_RSVD3) || (dm == DM_RSVD7);
        bad_level0     = !level_bit && !(trig_level && dm == DM_INIT);
        bad_broadcast  = (sh == SH_ALL_INCL) && (dm != DM_FIXED);
        bad_level_trig = trig_level && (sh != SH_ALL_INCL) &&
                         ((dm == DM_SMI) || (dm == DM_STARTUP));
        illegal  = reserved_code || bad_level0 || bad_broadcast || bad_level_trig;
        deassert = !illegal && !level_bit;
    end
endmodule

// File: rtl/ipi_mask_build.sv
module ipi_mask_build
    import ipi_dec_pkg::*;
#(
    parameter int NUM_UNITS = 16,
    parameter int SND_W     = 4
) (
    input  logic [1:0]           shorthand,
    input  logic [SND_W-1:0]     sender,
    input  logic [NUM_UNITS-1:0] hits,
    output logic [NUM_UNITS-1:0] mask
);
    shorthand_e sh;
    assign sh = shorthand_e'(shorthand);

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_bit
        logic is_sender;
        assign is_sender = (sender == SND_W'(i));
        always_comb begin
            unique case (sh)
                SH_NONE:     mask[i] = hits[i];
                SH_SELF:     mask[i] = is_sender;
                SH_ALL_INCL: mask[i] = 1'b1;
                SH_ALL_EXCL: mask[i] = !is_sender;
                default:     mask[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ipi_dest_decoder.sv
module ipi_dest_decoder
    import ipi_dec_pkg::*;
#(
    parameter int NUM_UNITS = 16,
    parameter int ID_W      = 8,
    localparam int SND_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic [1:0]                cmd_shorthand,
    input  logic                      cmd_dest_logical,
    input  logic [ID_W-1:0]           cmd_dest,
    input  logic [2:0]                cmd_dlv,
    input  logic                      cmd_trig_level,
    input  logic                      cmd_level,
    input  logic [SND_W-1:0]          cmd_sender,
    input  logic [NUM_UNITS*ID_W-1:0] unit_id,
    input  logic [NUM_UNITS*ID_W-1:0] unit_ldr,
    input  logic [NUM_UNITS-1:0]      unit_flat,
    output logic                      res_valid,
    output logic [NUM_UNITS-1:0]      res_mask,
    output logic                      res_error,
    output logic                      res_deassert
);
    dec_state_e             state_q;
    dec_state_e             state_d;
    logic [NUM_UNITS-1:0]   hits;
    logic [NUM_UNITS-1:0]   sel_mask;
    logic                   illegal;
    logic                   deassert;

    assign cmd_ready = 1'b1;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        ipi_unit_match #(.ID_W(ID_W)) u_match (
            .dest         (cmd_dest),
            .logical_mode (cmd_dest_logical),
            .phys_id      (unit_id[u*ID_W +: ID_W]),
            .log_id       (unit_ldr[u*ID_W +: ID_W]),
            .flat_fmt     (unit_flat[u]),
            .hit          (hits[u])
        );
    end

    ipi_mask_build #(.NUM_UNITS(NUM_UNITS), .SND_W(SND_W)) u_mask (
        .shorthand (cmd_shorthand),
        .sender    (cmd_sender),
        .hits      (hits),
        .mask      (sel_mask)
    );

    ipi_cmd_legality u_legal (
        .shorthand  (cmd_shorthand),
        .dlv        (cmd_dlv),
        .trig_level (cmd_trig_level),
        .level_bit  (cmd_level),
        .illegal    (illegal),
        .deassert   (deassert)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, STREAM, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = cmd_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = cmd_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_mask     <= '0;
            res_error    <= 1'b0;
            res_deassert <= 1'b0;
        end else if (cmd_valid) begin
            res_mask     <= illegal ? '0 : sel_mask;
            res_error    <= illegal;
            res_deassert <= deassert;
        end else begin
            res_mask     <= '0;
            res_error    <= 1'b0;
            res_deassert <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_LOADED);

    // Assertions
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> res_valid);
    assert_idle_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!res_valid && res_mask == '0));
    assert_self_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_shorthand == SH_SELF) |=> (res_error || $countones(res_mask) == 1));
    assert_excl_sender_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_shorthand == SH_ALL_EXCL) |=> (res_mask[$past(cmd_sender)] == 1'b0));
    assert_incl_nonfixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_shorthand == SH_ALL_INCL && cmd_dlv != DM_FIXED) |=> res_error);
    assert_level0_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_level && cmd_dlv != DM_INIT) |=> (res_error && !res_deassert));
    assert_err_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_error |-> (res_mask == '0 && !res_deassert));
endmodule

// File: tb/ipi_dest_decoder_bench.sv
module ipi_dest_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int IDW = 8;
    localparam int SW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_shorthand = '0;
    logic cmd_dest_logical = 1'b0;
    logic [IDW-1:0] cmd_dest = '0;
    logic [2:0] cmd_dlv = '0;
    logic cmd_trig_level = 1'b0;
    logic cmd_level = 1'b1;
    logic [SW-1:0] cmd_sender = '0;
    logic [N*IDW-1:0] unit_id;
    logic [N*IDW-1:0] unit_ldr;
    logic [N-1:0] unit_flat;
    logic res_valid;
    logic [N-1:0] res_mask;
    logic res_error;
    logic res_deassert;

    int n_checks = 0;
    int n_fail = 0;
    logic [N+1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_dest_decoder #(.NUM_UNITS(N), .ID_W(IDW)) u_ipi_dest_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_shorthand(cmd_shorthand), .cmd_dest_logical(cmd_dest_logical),
        .cmd_dest(cmd_dest), .cmd_dlv(cmd_dlv), .cmd_trig_level(cmd_trig_level),
        .cmd_level(cmd_level), .cmd_sender(cmd_sender), .unit_id(unit_id),
        .unit_ldr(unit_ldr), .unit_flat(unit_flat), .res_valid(res_valid),
        .res_mask(res_mask), .res_error(res_error), .res_deassert(res_deassert)
    );

    // Units 0..3 flat, logical ID one-hot; units 4,5 cluster 1; 6,7 cluster 2
    initial begin
        for (int i = 0; i < N; i++) begin
            unit_id[i*IDW +: IDW] = 8'h20 + 8'(i);
            if (i < 4) begin
                unit_flat[i] = 1'b1;
                unit_ldr[i*IDW +: IDW] = 8'h01 << i;
            end else begin
                unit_flat[i] = 1'b0;
                unit_ldr[i*IDW +: IDW] = {(i < 6) ? 4'h1 : 4'h2, 4'h1 << (i % 4)};
            end
        end
    end

    // Reference built from the requirements: {deassert, error, mask}
    function automatic logic [N+1:0] model(logic [1:0] sh, logic lg, logic [7:0] d,
                                           logic [2:0] dm, logic tr, logic lv, logic [SW-1:0] s);
        logic bad;
        logic [N-1:0] m;
        logic [7:0] lid;
        bad = 1'b0;
        if (dm == 3'b011 || dm == 3'b111) bad = 1'b1;           // R10
        if (sh == 2'b10 && dm != 3'b000) bad = 1'b1;            // R7
        if (tr && (dm == 3'b010 || dm == 3'b110)) bad = 1'b1;   // R8
        if (!lv && !(tr && dm == 3'b101)) bad = 1'b1;           // R9
        m = '0;
        for (int i = 0; i < N; i++) begin
            lid = unit_ldr[i*IDW +: IDW];
            case (sh)
                2'b01: m[i] = (int'(s) == i);
                2'b10: m[i] = 1'b1;
                2'b11: m[i] = (int'(s) != i);
                default: begin
                    if (d == 8'hFF) m[i] = 1'b1;
                    else if (!lg) m[i] = (unit_id[i*IDW +: IDW] == d);
                    else if (unit_flat[i]) m[i] = ((lid & d) != 0);
                    else m[i] = (lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 0);
                end
            endcase
        end
        if (bad) m = '0;
        return {(!bad && !lv), bad, m};
    endfunction

    task automatic send(string tag, logic [1:0] sh, logic lg, logic [7:0] d,
                        logic [2:0] dm, logic tr, logic lv, logic [SW-1:0] s);
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_shorthand = sh; cmd_dest_logical = lg; cmd_dest = d;
        cmd_dlv = dm; cmd_trig_level = tr; cmd_level = lv; cmd_sender = s;
        exp_q.push_back(model(sh, lg, d, dm, tr, lv, s));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            cmd_valid = 1'b0;
            cmd_dest = 8'hA5;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() != 0) begin
                logic [N+1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (!res_valid || {res_deassert, res_error, res_mask} != e) begin
                    n_fail++;
                    $display("FAIL %s: valid=%0b deassert/error/mask=%b expected valid=1 %b",
                             t, res_valid, {res_deassert, res_error, res_mask}, e);
                end
            end else begin
                n_checks++;
                if (res_valid || res_mask != '0 || res_error || res_deassert) begin
                    n_fail++;
                    $display("FAIL R1 idle: valid=%0b mask=%h err=%0b deas=%0b expected all 0",
                             res_valid, res_mask, res_error, res_deassert);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: run still active, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        n_checks++;   // R11 reset state
        if (res_valid || res_mask != '0 || res_error || res_deassert || !cmd_ready) begin
            n_fail++;
            $display("FAIL R11: valid=%0b mask=%h err=%0b ready=%0b expected 0,0,0,1",
                     res_valid, res_mask, res_error, cmd_ready);
        end
        #1 rst_n = 1'b1;
        idle(2);
        // R2 physical
        send("R2 phys hit", 2'b00, 1'b0, 8'h23, 3'b000, 1'b0, 1'b1, 3'd0);
        send("R2 phys bcast", 2'b00, 1'b0, 8'hFF, 3'b000, 1'b0, 1'b1, 3'd0);
        send("R2 phys miss", 2'b00, 1'b0, 8'h40, 3'b100, 1'b0, 1'b1, 3'd0);
        // R3/R4/R5 logical
        send("R3 flat", 2'b00, 1'b1, 8'h05, 3'b000, 1'b0, 1'b1, 3'd0);
        send("R4 cluster1", 2'b00, 1'b1, 8'h13, 3'b000, 1'b0, 1'b1, 3'd0);
        send("R4 cluster2", 2'b00, 1'b1, 8'h28, 3'b001, 1'b0, 1'b1, 3'd0);
        send("R4 cluster no share", 2'b00, 1'b1, 8'h1C, 3'b000, 1'b0, 1'b1, 3'd0);
        send("R5 logical bcast", 2'b00, 1'b1, 8'hFF, 3'b000, 1'b0, 1'b1, 3'd0);
        idle(1);
        // R6 shorthands ignore destination
        send("R6 self", 2'b01, 1'b0, 8'h23, 3'b000, 1'b0, 1'b1, 3'd5);
        send("R6 incl", 2'b10, 1'b1, 8'h01, 3'b000, 1'b0, 1'b1, 3'd2);
        send("R6 excl top", 2'b11, 1'b0, 8'h27, 3'b000, 1'b0, 1'b1, 3'd7);
        send("R6 excl zero", 2'b11, 1'b1, 8'hFF, 3'b100, 1'b0, 1'b1, 3'd0);
        // R7
        send("R7 incl NMI", 2'b10, 1'b0, 8'h00, 3'b100, 1'b0, 1'b1, 3'd0);
        send("R7 incl fixed level", 2'b10, 1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 3'd1);
        // R8
        send("R8 excl level SMI", 2'b11, 1'b0, 8'h00, 3'b010, 1'b1, 1'b1, 3'd1);
        send("R8 excl level NMI", 2'b11, 1'b0, 8'h00, 3'b100, 1'b1, 1'b1, 3'd1);
        send("R8 excl level INIT", 2'b11, 1'b0, 8'h00, 3'b101, 1'b1, 1'b1, 3'd3);
        send("R8 none level startup", 2'b00, 1'b0, 8'h21, 3'b110, 1'b1, 1'b1, 3'd0);
        send("R8 excl edge startup", 2'b11, 1'b0, 8'h00, 3'b110, 1'b0, 1'b1, 3'd4);
        // R9
        send("R9 init deassert", 2'b00, 1'b0, 8'h22, 3'b101, 1'b1, 1'b0, 3'd0);
        send("R9 excl deassert", 2'b11, 1'b0, 8'h00, 3'b101, 1'b1, 1'b0, 3'd6);
        send("R9 fixed lvl0", 2'b00, 1'b0, 8'h22, 3'b000, 1'b0, 1'b0, 3'd0);
        send("R9 init edge lvl0", 2'b00, 1'b0, 8'h22, 3'b101, 1'b0, 1'b0, 3'd0);
        // R10
        send("R10 rsvd3", 2'b11, 1'b0, 8'h00, 3'b011, 1'b0, 1'b1, 3'd0);
        send("R10 rsvd7", 2'b00, 1'b0, 8'hFF, 3'b111, 1'b0, 1'b1, 3'd0);
        idle(3);
        // R1 mixed stream with gaps
        for (int k = 0; k < 300; k++) begin
            r = $urandom;
            send("R1 stream", r[1:0], r[2], (r[3:0] == 4'h0) ? 8'hFF : 8'h20 ^ r[11:4],
                 r[14:12], r[15], (r[19:16] != 4'h0), r[22:20]);
            if (r[26:24] == 3'd0) idle(int'(r[28:27]) + 1);
        end
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule